// File: doc/BRIEF.md
# Multi-mode incremental encoder counter

This block keeps a signed position count for one incremental encoder channel. It takes three encoder lines (A, B and an index line C) and an 8-bit mode byte. The two low bits of the byte select how A and B turn into count steps. Bit 7 enables a debounce filter on all three lines. The block also loads a preset on a command edge and zeroes the count on a clear command. It reports sticky wrap flags when the count passes its positive or negative limit.

The count is a plain word whose top bit is the sign, so it reads as two's complement. A wrap flag clears in one of two ways: on the flag-clear command, or by itself once the count has moved more than a set number of steps (5000 by default) further in the wrapping direction. The conditioned levels of A, B and C are also sent out. Capture logic and comparator outputs built on this count belong to other blocks.

Top module: `enc_counter`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, both wrap flags are 0, the load-done bit is 0 and the three level outputs are 0.
- R2: With mode bits [1:0] = 00, each change of exactly one of A or B is one count. The order A,B = 00→10→11→01→00 counts up and the reverse order counts down. A change of both lines in the same sample is ignored.
- R3: With mode bits [1:0] = 01, only a rising edge of A counts: up when B is low, down when B is high. Falling A edges and B changes do not count.
- R4: With mode bits [1:0] = 10, A is a step pulse and B the direction. Each rising A edge counts up while B is low and down while B is high.
- R5: With mode bits [1:0] = 11, no activity on A or B changes the count.
- R6: A rising edge of the load command copies the preset value into the count and sets load-done to 1. Holding the command high does not load again.
- R7: The zero command forces the count to 0 and load-done to 0. It wins over a load and over a step in the same cycle.
- R8: An up step from 0x7FFFFFFF gives 0x80000000 and sets the high-wrap flag. A down step from 0x80000000 gives 0x7FFFFFFF and sets the low-wrap flag.
- R9: A set wrap flag clears by itself on the 5001st step past the wrap in the wrapping direction. Steps the other way subtract from that travel, down to no less than zero.
- R10: The flag-clear command resets both wrap flags and leaves the count unchanged.
- R11: Every line passes a two-flop synchronizer. With mode bit 7 = 1, a new level is taken only after it has held for 4 consecutive clocks, so a 3-clock pulse on A has no effect. With bit 7 = 0, a 1-clock pulse is taken.
- R12: The level outputs show the conditioned A, B and C lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder line A (asynchronous) |
| enc_b | input | 1 | Encoder line B (asynchronous) |
| enc_c | input | 1 | Encoder index line C (asynchronous) |
| cfg_mode | input | 8 | [1:0] count mode, [7] filter enable, others unused here |
| preset_val | input | 32 | Value loaded into the count on a load edge |
| load_cmd | input | 1 | Load command, acts on its rising edge |
| zero_cmd | input | 1 | Forces the count to zero while high |
| flag_clr_cmd | input | 1 | Clears both wrap flags while high |
| pos_count | output | 32 | Signed position count |
| lvl_a | output | 1 | Conditioned level of A |
| lvl_b | output | 1 | Conditioned level of B |
| lvl_c | output | 1 | Conditioned level of C |
| wrap_hi_flag | output | 1 | Sticky positive-wrap flag |
| wrap_lo_flag | output | 1 | Sticky negative-wrap flag |
| load_done | output | 1 | Set by a load, cleared by the zero command |

## Verification
With the filter off, an encoder line change shows on its level output three clocks later, after two synchronizer flops and the level register. The count follows one clock after that. With the filter on, both results come three clocks later still. The load, zero and flag-clear commands act at the first clock edge they are seen high. The driver therefore waits a fixed settle time longer than the longest of these paths: six clocks without the filter and ten with it. Only then does it push its expected item into the queue. The monitor compares that item against the registered outputs on a falling edge, when no input is changing.

// File: rtl/enc_pkg.sv
// Shared types for the encoder counter.
package enc_pkg;
    // Count mode, taken from mode byte bits [1:0].
    typedef enum logic [1:0] {
        MODE_X4   = 2'b00,
        MODE_X1   = 2'b01,
        MODE_PDIR = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_t;
endpackage

// File: rtl/enc_input_cond.sv
// Conditions one encoder line: a two-flop synchronizer, then an optional
// run-length filter. Assumes din is asynchronous to clk. When the filter is
// enabled, a new level is accepted only after the synchronized line has
// differed from the held level for FILT_LEN clocks in a row.
module enc_input_cond #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic filt_en,
    output logic lvl
);
    localparam int RW = $clog2(FILT_LEN + 1);

    logic          sync1, sync2;
    logic [RW-1:0] run;

    // Bring the line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= din;
            sync2 <= sync1;
        end
    end

    // Accept the new level at once, or after a full run when filtering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= 1'b0;
            run <= '0;
        end else if (!filt_en) begin
            lvl <= sync2;
            run <= '0;
        end else if (sync2 == lvl) begin
            run <= '0;
        end else if (run == RW'(FILT_LEN - 1)) begin
            lvl <= sync2;
            run <= '0;
        end else begin
            run <= run + RW'(1);
        end
    end

    // R11: under a steady filter, the level moves only to the value the synchronizer held.
    a_r11_filter_source: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && $past(filt_en) && (lvl != $past(lvl))) |-> (lvl == $past(sync2)));
endmodule

// File: rtl/enc_step_decode.sv
// Turns conditioned A/B levels into one-cycle up/down step strobes for the
// selected mode. Assumes a and b are already synchronous to clk.
module enc_step_decode
    import enc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a,
    input  logic      b,
    input  cnt_mode_t mode,
    output logic      step_up,
    output logic      step_dn
);
    logic a_p, b_p;
    logic chg_a, chg_b, a_rise;

    // Remember the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_p <= 1'b0;
            b_p <= 1'b0;
        end else begin
            a_p <= a;
            b_p <= b;
        end
    end

    // Decode one step, or none, from the current and previous levels.
    always_comb begin
        chg_a   = a ^ a_p;
        chg_b   = b ^ b_p;
        a_rise  = a & ~a_p;
        step_up = 1'b0;
        step_dn = 1'b0;
        case (mode)
            MODE_X4: begin
                if (chg_a ^ chg_b) begin
                    step_up = a ^ b_p;
                    step_dn = ~(a ^ b_p);
                end
            end
            MODE_X1, MODE_PDIR: begin
                step_up = a_rise & ~b;
                step_dn = a_rise & b;
            end
            default: begin
                step_up = 1'b0;
                step_dn = 1'b0;
            end
        endcase
    end

    // R2: never both directions in one cycle.
    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));
endmodule

// File: rtl/enc_pos_core.sv
// Holds the signed position count, the load and zero commands, and the sticky
// wrap flags with their travel-based auto clear. Assumes step_up and step_dn
// are never high together and all commands are synchronous to clk.
module enc_pos_core #(
    parameter int CNT_W      = 32,
    parameter int CLR_TRAVEL = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic [CNT_W-1:0] preset,
    input  logic             set_cmd,
    input  logic             clr_cnt,
    input  logic             clr_flags,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             unf,
    output logic             set_done
);
    localparam logic [CNT_W-1:0] MAXP = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] MINN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam int TW = $clog2(CLR_TRAVEL + 1);

    logic          set_q, set_rise, eff_up, eff_dn, wrap_up, wrap_dn;
    logic [TW-1:0] trav_o, trav_u;

    assign set_rise = set_cmd & ~set_q;
    assign eff_up   = step_up & ~clr_cnt & ~set_rise;
    assign eff_dn   = step_dn & ~clr_cnt & ~set_rise;
    assign wrap_up  = eff_up & (count == MAXP);
    assign wrap_dn  = eff_dn & (count == MINN);

    // Edge detector for the load command.
    always_ff @(posedge clk) begin
        if (!rst_n) set_q <= 1'b0;
        else        set_q <= set_cmd;
    end

    // Count update: zero beats load, load beats stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (clr_cnt)  count <= '0;
        else if (set_rise) count <= preset;
        else if (eff_up)   count <= count + CNT_W'(1);
        else if (eff_dn)   count <= count - CNT_W'(1);
    end

    // Load-done status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        set_done <= 1'b0;
        else if (clr_cnt)  set_done <= 1'b0;
        else if (set_rise) set_done <= 1'b1;
    end

    // Positive-wrap flag and its travel counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_flags) begin
            ovf    <= 1'b0;
            trav_o <= '0;
        end else if (wrap_up) begin
            ovf    <= 1'b1;
            trav_o <= '0;
        end else if (ovf && eff_up) begin
            if (trav_o == TW'(CLR_TRAVEL)) ovf <= 1'b0;
            else                           trav_o <= trav_o + TW'(1);
        end else if (ovf && eff_dn && (trav_o != '0)) begin
            trav_o <= trav_o - TW'(1);
        end
    end

    // Negative-wrap flag and its travel counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_flags) begin
            unf    <= 1'b0;
            trav_u <= '0;
        end else if (wrap_dn) begin
            unf    <= 1'b1;
            trav_u <= '0;
        end else if (unf && eff_dn) begin
            if (trav_u == TW'(CLR_TRAVEL)) unf <= 1'b0;
            else                           trav_u <= trav_u + TW'(1);
        end else if (unf && eff_up && (trav_u != '0)) begin
            trav_u <= trav_u - TW'(1);
        end
    end

    // R7: zero command empties the count and the done bit.
    a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (count == '0) && !set_done);
    // R6: a load edge copies the preset.
    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        (set_rise && !clr_cnt) |=> (count == $past(preset)) && set_done);
    // R5: without steps or commands the count holds.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_up && !step_dn && !clr_cnt && !set_rise) |=> $stable(count));
    // R8: flags rise only at the wrap points.
    a_r8_ovf_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> ($past(count) == MAXP));
    a_r8_unf_at_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf) |-> ($past(count) == MINN));
    // R10: flag clear empties both flags.
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flags |=> !ovf && !unf);
    // R9: an auto clear of the positive flag follows an up step.
    a_r9_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovf) && !$past(clr_flags)) |-> $past(step_up));
endmodule

// File: rtl/enc_counter.sv
// Top of the encoder counter: conditions the three encoder lines, decodes
// steps for the selected mode and keeps the signed count with wrap flags.
// Assumes the encoder lines are asynchronous and all commands are synchronous.
module enc_counter
    import enc_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int FILT_LEN   = 4,
    parameter int CLR_TRAVEL = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_c,
    input  logic [7:0]       cfg_mode,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             load_cmd,
    input  logic             zero_cmd,
    input  logic             flag_clr_cmd,
    output logic [CNT_W-1:0] pos_count,
    output logic             lvl_a,
    output logic             lvl_b,
    output logic             lvl_c,
    output logic             wrap_hi_flag,
    output logic             wrap_lo_flag,
    output logic             load_done
);
    localparam int NLINE = 3;

    logic [NLINE-1:0] raw_in, lvl;
    logic             up, dn, filt_en;
    cnt_mode_t        mode;
    logic             cfg_unused;

    assign raw_in     = {enc_c, enc_b, enc_a};
    assign filt_en    = cfg_mode[7];
    assign mode       = cnt_mode_t'(cfg_mode[1:0]);
    assign cfg_unused = ^cfg_mode[6:2];

    // One conditioner per encoder line.
    for (genvar i = 0; i < NLINE; i++) begin : g_line
        enc_input_cond #(.FILT_LEN(FILT_LEN)) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (raw_in[i]),
            .filt_en (filt_en),
            .lvl     (lvl[i])
        );
    end

    enc_step_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .a       (lvl[0]),
        .b       (lvl[1]),
        .mode    (mode),
        .step_up (up),
        .step_dn (dn)
    );

    enc_pos_core #(.CNT_W(CNT_W), .CLR_TRAVEL(CLR_TRAVEL)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up   (up),
        .step_dn   (dn),
        .preset    (preset_val),
        .set_cmd   (load_cmd),
        .clr_cnt   (zero_cmd),
        .clr_flags (flag_clr_cmd),
        .count     (pos_count),
        .ovf       (wrap_hi_flag),
        .unf       (wrap_lo_flag),
        .set_done  (load_done)
    );

    assign lvl_a = lvl[0];
    assign lvl_b = lvl[1];
    assign lvl_c = lvl[2];

    // R5: the reserved mode produces no steps.
    a_r5_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |-> (!up && !dn));
endmodule

// File: tb/tb_enc_counter.sv
`timescale 1ns/1ps
module tb_enc_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_c = 1'b0;
    logic [7:0]  cfg_mode = 8'h00;
    logic [31:0] preset_val = '0;
    logic        load_cmd = 1'b0, zero_cmd = 1'b0, flag_clr_cmd = 1'b0;
    logic [31:0] pos_count;
    logic        lvl_a, lvl_b, lvl_c, wrap_hi_flag, wrap_lo_flag, load_done;

    enc_counter dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_c(enc_c),
        .cfg_mode(cfg_mode), .preset_val(preset_val), .load_cmd(load_cmd),
        .zero_cmd(zero_cmd), .flag_clr_cmd(flag_clr_cmd), .pos_count(pos_count),
        .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c), .wrap_hi_flag(wrap_hi_flag),
        .wrap_lo_flag(wrap_lo_flag), .load_done(load_done)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [31:0] cnt;
        logic        hi, lo, done;
        logic [2:0]  lv;
        string       req;
    } exp_t;

    exp_t q[$];
    int   checks = 0, failures = 0;
    int   settle = 6;
    bit   done_flag = 0;

    // Reference model built from the requirements.
    logic [31:0] m_cnt = '0;
    logic        m_hi = 0, m_lo = 0, m_done = 0, m_a = 0, m_b = 0, m_c = 0;
    int          t_hi = 0, t_lo = 0;

    task automatic m_step(input bit up);
        if (up) begin
            if (m_cnt == 32'h7FFF_FFFF) begin m_hi = 1; t_hi = 0; end
            else if (m_hi) begin t_hi++; if (t_hi > 5000) m_hi = 0; end
            if (m_lo && t_lo > 0) t_lo--;
            m_cnt = m_cnt + 1;
        end else begin
            if (m_cnt == 32'h8000_0000) begin m_lo = 1; t_lo = 0; end
            else if (m_lo) begin t_lo++; if (t_lo > 5000) m_lo = 0; end
            if (m_hi && t_hi > 0) t_hi--;
            m_cnt = m_cnt - 1;
        end
    endtask

    // Driver side: push the model state as the expected item.
    task automatic expect_state(input string req);
        exp_t it;
        it.cnt = m_cnt; it.hi = m_hi; it.lo = m_lo; it.done = m_done;
        it.lv = {m_c, m_b, m_a}; it.req = req;
        @(posedge clk); #1;
        q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic set_lines(input bit a, input bit b, input bit c);
        @(negedge clk);
        enc_a = a; enc_b = b; enc_c = c;
        m_a = a; m_b = b; m_c = c;
        repeat (settle) @(negedge clk);
    endtask

    // One step pulse on A with B as given; counts as one step of the model.
    task automatic pulse(input bit b, input bit counts);
        set_lines(0, b, m_c);
        set_lines(1, b, m_c);
        if (counts) m_step(!b);
        set_lines(0, b, m_c);
    endtask

    task automatic fast_pulses(input bit b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); enc_a = 1'b1;
            @(negedge clk); enc_a = 1'b0;
            m_step(!b);
        end
        repeat (settle) @(negedge clk);
    endtask

    task automatic cmd_pulse(input bit ld, input bit zr, input bit fc);
        @(negedge clk);
        load_cmd = ld; zero_cmd = zr; flag_clr_cmd = fc;
        @(negedge clk);
        load_cmd = 1'b0; zero_cmd = 1'b0; flag_clr_cmd = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pop and compare against the registered outputs.
    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (pos_count !== it.cnt || wrap_hi_flag !== it.hi || wrap_lo_flag !== it.lo ||
                load_done !== it.done || {lvl_c, lvl_b, lvl_a} !== it.lv) begin
                failures++;
                $display("FAIL %s: got cnt=%h hi=%b lo=%b done=%b lv=%b exp cnt=%h hi=%b lo=%b done=%b lv=%b",
                         it.req, pos_count, wrap_hi_flag, wrap_lo_flag, load_done,
                         {lvl_c, lvl_b, lvl_a}, it.cnt, it.hi, it.lo, it.done, it.lv);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++; failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        expect_state("R1 reset");

        // R12 / R5: levels follow in the reserved mode, count stays.
        cfg_mode = 8'h03;
        set_lines(1, 0, 1);
        expect_state("R12 levels 101");
        expect_state("R5 reserved hold");
        set_lines(0, 1, 0);
        expect_state("R12 levels 010");
        set_lines(0, 0, 0);

        // R2: 4x quadrature.
        cfg_mode = 8'h00;
        set_lines(1, 0, 0); m_step(1); expect_state("R2 up 10");
        set_lines(1, 1, 0); m_step(1); expect_state("R2 up 11");
        set_lines(0, 1, 0); m_step(1); expect_state("R2 up 01");
        set_lines(0, 0, 0); m_step(1); expect_state("R2 up 00");
        set_lines(0, 1, 0); m_step(0); expect_state("R2 down 01");
        set_lines(1, 1, 0); m_step(0); expect_state("R2 down 11");
        set_lines(0, 0, 0); expect_state("R2 double change ignored");

        // R3: 1x quadrature.
        cfg_mode = 8'h01;
        set_lines(1, 0, 0); m_step(1); expect_state("R3 A rise B low");
        set_lines(0, 0, 0); expect_state("R3 A fall ignored");
        set_lines(0, 1, 0); expect_state("R3 B change ignored");
        set_lines(1, 1, 0); m_step(0); expect_state("R3 A rise B high");
        set_lines(0, 0, 0);

        // R4: pulse and direction.
        cfg_mode = 8'h02;
        for (int i = 0; i < 3; i++) pulse(0, 1);
        expect_state("R4 three up pulses");
        for (int i = 0; i < 2; i++) pulse(1, 1);
        expect_state("R4 two down pulses");
        set_lines(0, 0, 0);

        // R5: reserved mode ignores pulses.
        cfg_mode = 8'h03;
        pulse(0, 0); pulse(1, 0);
        expect_state("R5 reserved ignores pulses");
        set_lines(0, 0, 0);

        // R6: load on edge only.
        preset_val = 32'd1234;
        cmd_pulse(1, 0, 0); m_cnt = 32'd1234; m_done = 1;
        expect_state("R6 load edge");
        @(negedge clk); load_cmd = 1'b1; preset_val = 32'd77;
        @(negedge clk); m_cnt = 32'd77;
        @(negedge clk); preset_val = 32'd99;
        repeat (4) @(negedge clk);
        expect_state("R6 held load no reload");
        load_cmd = 1'b0;

        // R7: zero command, and its priority over a load.
        cmd_pulse(0, 1, 0); m_cnt = '0; m_done = 0;
        expect_state("R7 zero");
        preset_val = 32'd55;
        cmd_pulse(1, 1, 0);
        expect_state("R7 zero beats load");

        // R8 / R10: wrap flags.
        cfg_mode = 8'h02;
        preset_val = 32'h7FFF_FFFF;
        cmd_pulse(1, 0, 0); m_cnt = preset_val; m_done = 1;
        pulse(0, 1);
        expect_state("R8 positive wrap");
        cmd_pulse(0, 0, 1); m_hi = 0; m_lo = 0; t_hi = 0; t_lo = 0;
        expect_state("R10 flag clear");
        preset_val = 32'h8000_0000;
        cmd_pulse(1, 0, 0); m_cnt = preset_val;
        pulse(1, 1);
        expect_state("R8 negative wrap");
        cmd_pulse(0, 0, 1); m_hi = 0; m_lo = 0; t_hi = 0; t_lo = 0;

        // R9: auto clear after travel, both directions.
        set_lines(0, 0, 0);
        preset_val = 32'h7FFF_FFFF;
        cmd_pulse(1, 0, 0); m_cnt = preset_val;
        fast_pulses(0, 1);
        fast_pulses(0, 5000);
        expect_state("R9 high flag kept at 5000");
        fast_pulses(0, 1);
        expect_state("R9 high flag auto clear");
        set_lines(0, 1, 0);
        preset_val = 32'h8000_0000;
        cmd_pulse(1, 0, 0); m_cnt = preset_val;
        fast_pulses(1, 5001);
        expect_state("R9 low flag kept at 5000");
        fast_pulses(1, 1);
        expect_state("R9 low flag auto clear");

        // R11: filter.
        set_lines(0, 0, 0);
        cfg_mode = 8'h82; settle = 10;
        @(negedge clk); enc_a = 1'b1;
        repeat (3) @(negedge clk); enc_a = 1'b0;
        repeat (10) @(negedge clk);
        expect_state("R11 filtered 3-clock pulse rejected");
        @(negedge clk); enc_a = 1'b1;
        repeat (6) @(negedge clk); enc_a = 1'b0;
        m_step(1);
        repeat (10) @(negedge clk);
        expect_state("R11 filtered 6-clock pulse taken");
        cfg_mode = 8'h02; settle = 6;
        repeat (4) @(negedge clk);
        fast_pulses(0, 1);
        expect_state("R11 unfiltered 1-clock pulse taken");

        repeat (4) @(negedge clk);
        done_flag = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule